// File: doc/BRIEF.md
# Gauss-Seidel Sweep Refiner for Complex Symbol Estimates

This block improves an estimate of an N-element complex vector s that solves W·s = b. W is an N×N Hermitian matrix and b is a matched-filter vector. It runs a small number of Gauss-Seidel sweeps and does not invert the matrix. Each sweep is a forward solve with the lower-triangular part of W, and the strictly upper part is applied to the estimate from the previous sweep. The elements are updated in place and in index order. As a result, lower-indexed elements are already refreshed when a higher-indexed element uses them. The first sweep begins from an externally computed seed rather than from zero. The host supplies the reciprocals of the diagonal entries, so no divider is needed.

A single complex multiply-accumulate unit handles one matrix term per cycle. The problem enters as one parallel word through a valid/ready handshake. The block latches the matrix, the right-hand side, the seed, the reciprocal diagonal and the sweep count when `in_valid && in_ready` is high at a rising clock edge. `in_ready` is high only while the block is idle, so the upstream side has to wait while a job runs. The refined vector is presented with `out_valid`. It stays stable until `out_ready` is seen high at a clock edge, which is the downstream back-pressure. `done` is a plain status pulse.

All values are signed two's complement in Q3.12 format (DW=16, FW=12). Element i of a vector port is held in bits [i*DW +: DW]. Entry (row i, column j) of a matrix port is held in bits [(i*N+j)*DW +: DW].

Top module: `gs_refiner`

## Requirements
- R1: While reset is held low, and in the cycle after it is released, `in_ready` is 1, `out_valid` is 0 and `done` is 0.
- R2: A job is taken only when `in_valid && in_ready` is high at a rising edge. From that edge until the result is handed off, `in_ready` stays 0. `in_ready` and `out_valid` are never high together.
- R3: Element i is updated as follows. acc = b_i·2^FW − Σ_{j≠i} W_ij·s_j, using full-precision complex products. Then r = floor(acc / 2^FW), and the new s_i = sat(floor(r·rdiag_i / 2^FW)). The real and imaginary parts are handled the same way, and rdiag_i is real.
- R4: Within a sweep, elements are updated in the order 0 to N−1. For j < i the term uses s_j as already updated in the current sweep. For j > i it uses the value from the previous sweep, or the seed in the first sweep.
- R5: `in_sweeps` (2 bits) sets the number of sweeps K, from 0 to 3. The first sweep starts from `in_s0`. With K = 0 the seed is passed to the output unchanged.
- R6: Every updated element saturates to the signed DW-bit range, [−32768, 32767].
- R7: `out_valid` goes high K·N·(N+1) rising edges after the accepting edge. For K = 0 it goes high on the accepting edge itself.
- R8: `done` is a one-cycle pulse that rises in the same cycle in which `out_valid` rises, after the last element of the final sweep has been written.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_s_re` and `out_s_im` hold their values. An edge with `out_ready` high clears `out_valid`.
- R10: Changes on the input data ports, on `in_sweeps` and on `in_valid` while a job is in progress have no effect on the result of that job.
- R11: The diagonal entries of `in_w_re`/`in_w_im` are never used. Only `in_rdiag` scales the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Problem word is valid |
| in_ready | output | 1 | Block is idle and can take a problem |
| in_w_re | input | N*N*DW | Real parts of W, row-major |
| in_w_im | input | N*N*DW | Imaginary parts of W, row-major |
| in_b_re | input | N*DW | Real parts of the matched-filter vector |
| in_b_im | input | N*DW | Imaginary parts of the matched-filter vector |
| in_s0_re | input | N*DW | Real parts of the seed estimate |
| in_s0_im | input | N*DW | Imaginary parts of the seed estimate |
| in_rdiag | input | N*DW | Reciprocal of each diagonal entry, real |
| in_sweeps | input | 2 | Number of sweeps K |
| out_valid | output | 1 | Refined estimate is valid |
| out_ready | input | 1 | Downstream accepts the estimate |
| out_s_re | output | N*DW | Real parts of the refined estimate |
| out_s_im | output | N*DW | Imaginary parts of the refined estimate |
| done | output | 1 | One-cycle pulse when the last sweep completes |

## Verification
Two events can occur in the same cycle: the write of the final element of the last sweep, and the switch of the handshake from busy to result-valid. In that cycle the done pulse must also coincide with the rising `out_valid`. Each table vector provokes this case. The bench counts edges from acceptance to the rise of `out_valid` and compares the count with K·N·(N+1). It checks that `done` is high only in that first valid cycle. It also compares all 2N output lanes with a bit-exact model of the in-place update. A missed or duplicated final write would therefore appear either as an element value taken from the wrong sweep or as a shifted latency. The K = 0 case puts the acceptance edge and the result-valid edge on the same edge.

// File: rtl/gs_pkg.sv
package gs_pkg;

  typedef enum logic [1:0] {
    GS_IDLE = 2'd0,
    GS_RUN  = 2'd1,
    GS_HOLD = 2'd2
  } gs_state_e;

endpackage

// File: rtl/gs_seq.sv
module gs_seq #(
  parameter int N  = 8,
  parameter int KW = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [KW-1:0] k_cfg,
  output logic [IW-1:0] row,
  output logic [IW-1:0] col,
  output logic          mac_en,
  output logic          first_term,
  output logic          skip_term,
  output logic          wr_en,
  output logic          last_wr
);

  localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

  logic          run_q;
  logic          wr_q;
  logic [KW-1:0] sweep_q;
  logic [KW-1:0] k_q;
  logic [IW-1:0] row_q;
  logic [IW-1:0] col_q;
  logic          last_sweep;

  assign last_sweep = (sweep_q == k_q - KW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      wr_q    <= 1'b0;
      sweep_q <= '0;
      k_q     <= '0;
      row_q   <= '0;
      col_q   <= '0;
    end else if (start) begin
      run_q   <= 1'b1;
      wr_q    <= 1'b0;
      sweep_q <= '0;
      k_q     <= k_cfg;
      row_q   <= '0;
      col_q   <= '0;
    end else if (run_q) begin
      if (!wr_q) begin
        if (col_q == LAST_IDX) wr_q <= 1'b1;
        else                   col_q <= col_q + IW'(1);
      end else begin
        wr_q  <= 1'b0;
        col_q <= '0;
        if (row_q == LAST_IDX) begin
          row_q <= '0;
          if (last_sweep) run_q   <= 1'b0;
          else            sweep_q <= sweep_q + KW'(1);
        end else begin
          row_q <= row_q + IW'(1);
        end
      end
    end
  end

  assign row        = row_q;
  assign col        = col_q;
  assign mac_en     = run_q && !wr_q;
  assign first_term = (col_q == '0);
  assign skip_term  = (col_q == row_q);
  assign wr_en      = run_q && wr_q;
  assign last_wr    = wr_en && (row_q == LAST_IDX) && last_sweep;

  // R5: the sweep counter never reaches the configured count while running
  p_sweep_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (sweep_q < k_q));

  // R7: each element write phase lasts exactly one cycle
  p_wr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R4: the write phase is entered only from the last column
  p_wr_after_scan_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_en && col_q != LAST_IDX) |=> !wr_en);

endmodule

// File: rtl/gs_cmac.sv
module gs_cmac #(
  parameter int DW = 16,
  parameter int FW = 12,
  parameter int AW = 37
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 first_term,
  input  logic                 skip_term,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  input  logic signed [DW-1:0] w_re,
  input  logic signed [DW-1:0] w_im,
  input  logic signed [DW-1:0] s_re,
  input  logic signed [DW-1:0] s_im,
  output logic signed [AW-1:0] acc_re,
  output logic signed [AW-1:0] acc_im
);

  logic signed [2*DW-1:0] p_rr, p_ii, p_ri, p_ir;
  logic signed [AW-1:0]   t_re, t_im;
  logic signed [AW-1:0]   base_re, base_im;
  logic signed [AW-1:0]   acc_re_q, acc_im_q;

  always_comb begin
    p_rr = w_re * s_re;
    p_ii = w_im * s_im;
    p_ri = w_re * s_im;
    p_ir = w_im * s_re;
    if (skip_term) begin
      t_re = '0;
      t_im = '0;
    end else begin
      t_re = AW'(p_rr) - AW'(p_ii);
      t_im = AW'(p_ri) + AW'(p_ir);
    end
    if (first_term) begin
      base_re = AW'(b_re) <<< FW;
      base_im = AW'(b_im) <<< FW;
    end else begin
      base_re = acc_re_q;
      base_im = acc_im_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_re_q <= '0;
      acc_im_q <= '0;
    end else if (en) begin
      acc_re_q <= base_re - t_re;
      acc_im_q <= base_im - t_im;
    end
  end

  assign acc_re = acc_re_q;
  assign acc_im = acc_im_q;

  // R3: the accumulator only moves during the multiply-accumulate phase
  p_acc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(acc_re_q) && $stable(acc_im_q)));

endmodule

// File: rtl/gs_scale.sv
module gs_scale #(
  parameter int DW = 16,
  parameter int FW = 12,
  parameter int AW = 37,
  localparam int RW = AW - FW,
  localparam int PW = RW + DW
) (
  input  logic signed [AW-1:0] acc,
  input  logic signed [DW-1:0] rdiag,
  output logic signed [DW-1:0] q
);

  localparam logic signed [PW-1:0] MAXV = PW'((2 ** (DW - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

  logic signed [AW-1:0] shifted;
  logic signed [RW-1:0] resid;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] scaled;

  always_comb begin
    shifted = acc >>> FW;
    resid   = RW'(shifted);
    prod    = PW'(resid) * PW'(rdiag);
    scaled  = prod >>> FW;
    if (scaled > MAXV)      q = DW'(MAXV);
    else if (scaled < MINV) q = DW'(MINV);
    else                    q = DW'(scaled);
  end

endmodule

// File: rtl/gs_refiner.sv
module gs_refiner #(
  parameter int N  = 8,
  parameter int DW = 16,
  parameter int FW = 12,
  parameter int KW = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int AW = 2 * DW + IW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [N*N*DW-1:0] in_w_re,
  input  logic [N*N*DW-1:0] in_w_im,
  input  logic [N*DW-1:0]   in_b_re,
  input  logic [N*DW-1:0]   in_b_im,
  input  logic [N*DW-1:0]   in_s0_re,
  input  logic [N*DW-1:0]   in_s0_im,
  input  logic [N*DW-1:0]   in_rdiag,
  input  logic [KW-1:0]     in_sweeps,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [N*DW-1:0]   out_s_re,
  output logic [N*DW-1:0]   out_s_im,
  output logic              done
);

  import gs_pkg::*;

  gs_state_e st_q;
  logic      done_q;

  logic signed [DW-1:0] w_re [N][N];
  logic signed [DW-1:0] w_im [N][N];
  logic signed [DW-1:0] b_re [N];
  logic signed [DW-1:0] b_im [N];
  logic signed [DW-1:0] rd   [N];
  logic signed [DW-1:0] s_re [N];
  logic signed [DW-1:0] s_im [N];

  logic          accept, start;
  logic [IW-1:0] row, col;
  logic          mac_en, first_term, skip_term, wr_en, last_wr;
  logic signed [AW-1:0] acc_re, acc_im;
  logic signed [DW-1:0] new_re, new_im;

  assign accept = (st_q == GS_IDLE) && in_valid;
  assign start  = accept && (in_sweeps != '0);

  gs_seq #(.N(N), .KW(KW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .k_cfg      (in_sweeps),
    .row        (row),
    .col        (col),
    .mac_en     (mac_en),
    .first_term (first_term),
    .skip_term  (skip_term),
    .wr_en      (wr_en),
    .last_wr    (last_wr)
  );

  gs_cmac #(.DW(DW), .FW(FW), .AW(AW)) u_cmac (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (mac_en),
    .first_term (first_term),
    .skip_term  (skip_term),
    .b_re       (b_re[row]),
    .b_im       (b_im[row]),
    .w_re       (w_re[row][col]),
    .w_im       (w_im[row][col]),
    .s_re       (s_re[col]),
    .s_im       (s_im[col]),
    .acc_re     (acc_re),
    .acc_im     (acc_im)
  );

  gs_scale #(.DW(DW), .FW(FW), .AW(AW)) u_scale_re (
    .acc   (acc_re),
    .rdiag (rd[row]),
    .q     (new_re)
  );

  gs_scale #(.DW(DW), .FW(FW), .AW(AW)) u_scale_im (
    .acc   (acc_im),
    .rdiag (rd[row]),
    .q     (new_im)
  );

  // problem storage and in-place estimate
  always_ff @(posedge clk) begin
    if (accept) begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          w_re[i][j] <= in_w_re[(i*N+j)*DW +: DW];
          w_im[i][j] <= in_w_im[(i*N+j)*DW +: DW];
        end
        b_re[i] <= in_b_re[i*DW +: DW];
        b_im[i] <= in_b_im[i*DW +: DW];
        rd[i]   <= in_rdiag[i*DW +: DW];
        s_re[i] <= in_s0_re[i*DW +: DW];
        s_im[i] <= in_s0_im[i*DW +: DW];
      end
    end else if (wr_en) begin
      s_re[row] <= new_re;
      s_im[row] <= new_im;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= GS_IDLE;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        GS_IDLE: if (accept) begin
          if (in_sweeps == '0) begin
            st_q   <= GS_HOLD;
            done_q <= 1'b1;
          end else begin
            st_q <= GS_RUN;
          end
        end
        GS_RUN: if (last_wr) begin
          st_q   <= GS_HOLD;
          done_q <= 1'b1;
        end
        GS_HOLD: if (out_ready) st_q <= GS_IDLE;
        default: st_q <= GS_IDLE;
      endcase
    end
  end

  assign in_ready  = (st_q == GS_IDLE);
  assign out_valid = (st_q == GS_HOLD);
  assign done      = done_q;

  for (genvar g = 0; g < N; g++) begin : g_out
    assign out_s_re[g*DW +: DW] = s_re[g];
    assign out_s_im[g*DW +: DW] = s_im[g];
  end

  // R2: never ready for input while a result is pending
  p_ready_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R9: held result is stable under back-pressure
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_s_re) && $stable(out_s_im)));

  // R8: done only accompanies a valid result
  p_done_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid);

  // R8: every rise of out_valid carries the done pulse
  p_rise_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> done);

  // R10: a running job is not disturbed by the input handshake
  p_run_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == GS_RUN && !last_wr) |=> (st_q == GS_RUN));

endmodule

// File: tb/gs_refiner_test.sv
module gs_refiner_test;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int DW = 16;
  localparam int FW = 12;

  localparam int NV = 6;
  localparam int T_SEED  [NV] = '{11, 23, 37, 41, 59, 73};
  localparam int T_K     [NV] = '{1, 2, 3, 0, 3, 2};
  localparam int T_DIAG  [NV] = '{16384, 16384, 12288, 16384, 20480, 8192};
  localparam int T_OFF   [NV] = '{1200, 1500, 1000, 1200, 2000, 600};
  localparam int T_AMP   [NV] = '{8000, 8000, 6000, 8000, 9000, 5000};
  localparam int T_STALL [NV] = '{0, 3, 1, 2, 0, 4};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [N*N*DW-1:0] in_w_re = '0, in_w_im = '0;
  logic [N*DW-1:0]   in_b_re = '0, in_b_im = '0, in_s0_re = '0, in_s0_im = '0, in_rdiag = '0;
  logic [1:0]        in_sweeps = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [N*DW-1:0] out_s_re, out_s_im;
  logic done;

  int n_cmp = 0;
  int n_bad = 0;
  bit [31:0] lcg;

  int wr [N][N];
  int wi [N][N];
  int br [N];
  int bi [N];
  int s0r [N];
  int s0i [N];
  int rdv [N];
  int er [N];
  int ei [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  gs_refiner uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_w_re(in_w_re), .in_w_im(in_w_im), .in_b_re(in_b_re), .in_b_im(in_b_im),
    .in_s0_re(in_s0_re), .in_s0_im(in_s0_im), .in_rdiag(in_rdiag),
    .in_sweeps(in_sweeps), .out_valid(out_valid), .out_ready(out_ready),
    .out_s_re(out_s_re), .out_s_im(out_s_im), .done(done)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic int rnd(input int amp);
    int v;
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    v = int'(lcg[30:8]);
    return (v % (2 * amp + 1)) - amp;
  endfunction

  function automatic int sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  // bit-exact model of R3/R4/R5/R6/R11; diagonal of W never read
  task automatic model(input int k);
    longint ar, ai, pr, pi;
    for (int i = 0; i < N; i++) begin
      er[i] = s0r[i];
      ei[i] = s0i[i];
    end
    for (int s = 0; s < k; s++) begin
      for (int i = 0; i < N; i++) begin
        ar = longint'(br[i]) <<< FW;
        ai = longint'(bi[i]) <<< FW;
        for (int j = 0; j < N; j++) begin
          if (j != i) begin
            ar -= longint'(wr[i][j]) * er[j] - longint'(wi[i][j]) * ei[j];
            ai -= longint'(wr[i][j]) * ei[j] + longint'(wi[i][j]) * er[j];
          end
        end
        pr = (ar >>> FW) * rdv[i];
        pi = (ai >>> FW) * rdv[i];
        er[i] = sat16(pr >>> FW);
        ei[i] = sat16(pi >>> FW);
      end
    end
  endtask

  task automatic gen(input int seed, input int diag, input int off, input int amp);
    lcg = 32'(seed);
    for (int i = 0; i < N; i++) begin
      wr[i][i] = rnd(30000);
      wi[i][i] = rnd(30000);
      rdv[i] = (1 << 24) / diag;
      br[i]  = rnd(amp);
      bi[i]  = rnd(amp);
      s0r[i] = rnd(amp / 2);
      s0i[i] = rnd(amp / 2);
      for (int j = 0; j < i; j++) begin
        wr[i][j] = rnd(off);
        wi[i][j] = rnd(off);
        wr[j][i] = wr[i][j];
        wi[j][i] = -wi[i][j];
      end
    end
  endtask

  task automatic drive_inputs();
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        in_w_re[(i*N+j)*DW +: DW] = 16'(wr[i][j]);
        in_w_im[(i*N+j)*DW +: DW] = 16'(wi[i][j]);
      end
      in_b_re[i*DW +: DW]  = 16'(br[i]);
      in_b_im[i*DW +: DW]  = 16'(bi[i]);
      in_s0_re[i*DW +: DW] = 16'(s0r[i]);
      in_s0_im[i*DW +: DW] = 16'(s0i[i]);
      in_rdiag[i*DW +: DW] = 16'(rdv[i]);
    end
  endtask

  task automatic scramble_inputs();
    for (int i = 0; i < N * N * DW / 32; i++) begin
      in_w_re[i*32 +: 32] = $urandom;
      in_w_im[i*32 +: 32] = $urandom;
    end
    for (int i = 0; i < N * DW / 32; i++) begin
      in_b_re[i*32 +: 32]  = $urandom;
      in_b_im[i*32 +: 32]  = $urandom;
      in_s0_re[i*32 +: 32] = $urandom;
      in_rdiag[i*32 +: 32] = $urandom;
    end
    in_sweeps = 2'd3;
  endtask

  task automatic run_job(input int k, input int stall, input string tag);
    int lat;
    logic [N*DW-1:0] hold_re, hold_im;
    @(negedge clk);
    drive_inputs();
    in_sweeps = 2'(k);
    in_valid = 1'b1;
    chk({tag, " R2 ready before accept"}, in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    // R10: keep in_valid high and garble every input during the job
    scramble_inputs();
    lat = 0;
    if (k != 0) chk({tag, " R2 busy after accept"}, in_ready, 0);
    while (!out_valid && lat < 2000) begin
      lat++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk({tag, " R7 latency"}, lat, k * N * (N + 1));
    chk({tag, " R8 done with valid"}, done, 1);
    model(k);
    for (int i = 0; i < N; i++) begin
      chk({tag, " R3/R4/R5 re"}, $signed(out_s_re[i*DW +: DW]), er[i]);
      chk({tag, " R3/R4/R5 im"}, $signed(out_s_im[i*DW +: DW]), ei[i]);
    end
    hold_re = out_s_re;
    hold_im = out_s_im;
    for (int c = 0; c < stall; c++) begin
      @(negedge clk);
      chk({tag, " R9 valid held"}, out_valid, 1);
      chk({tag, " R9 data held"}, longint'(out_s_re == hold_re && out_s_im == hold_im), 1);
      chk({tag, " R8 done single"}, done, 0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk({tag, " R9 valid cleared"}, out_valid, 0);
    chk({tag, " R2 ready after handoff"}, in_ready, 1);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", in_ready, 1);
    chk("R1 valid in reset", out_valid, 0);
    chk("R1 done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", in_ready, 1);
    chk("R1 valid after reset", out_valid, 0);

    for (int v = 0; v < NV; v++) begin
      gen(T_SEED[v], T_DIAG[v], T_OFF[v], T_AMP[v]);
      run_job(T_K[v], T_STALL[v], $sformatf("vec%0d", v));
    end

    // identity matrix, unit reciprocal, one sweep: result equals b (R3, R11)
    gen(101, 4096, 0, 7000);
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (i != j) begin wr[i][j] = 0; wi[i][j] = 0; end
      end
      rdv[i] = 4096;
    end
    run_job(1, 0, "ident");
    for (int i = 0; i < N; i++) begin
      chk("R11 ident re", er[i], br[i]);
      chk("R11 ident im", ei[i], bi[i]);
    end

    // saturation corner: large reciprocal drives both limits (R6)
    gen(202, 4096, 0, 100);
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (i != j) begin wr[i][j] = 0; wi[i][j] = 0; end
      end
      rdv[i] = 32767;
      br[i] = 0;
      bi[i] = 0;
    end
    br[0] = 8192;
    bi[0] = -8192;
    run_job(1, 0, "sat");
    chk("R6 sat high", er[0], 32767);
    chk("R6 sat low", ei[0], -32768);

    report();
  end

endmodule